// File: doc/BRIEF.md
# Express-Bypass Switch Allocator

This block handles switch allocation and pipeline sequencing for one router port group that carries both ordinary virtual channels and express virtual channels. Every input virtual channel has a small state machine that takes the head flit of an ordinary packet through a route stage and a VC-wait stage before it may ask for the crossbar. Body and tail flits then ask for the crossbar directly. A flit that does not win stays in its input buffer and asks again in the next cycle. A grant pops the flit from its buffer, and the crossbar select is registered, so traversal happens in the following cycle.

Express flits that pass through this router as an intermediate bypass hop never enter the allocator. A one-bit lookahead for each output arrives one cycle ahead of the express flit. In the cycle it is high, that output is taken out of ordinary arbitration. In the next cycle the output is driven from its dedicated express lane, so the express flit needs no buffer and has no extra delay. At express endpoint routers the flit behaves like an ordinary one: `in_vc_ok` carries both the VC-allocation result and the confirmation that the next express endpoint has a free buffer.

The per-channel state machine has four states:
- `ST_IDLE` goes to `ST_ROUTE` when a head flit is present.
- `ST_ROUTE` goes to `ST_VCWAIT` unconditionally.
- `ST_VCWAIT` goes to `ST_SWREQ` when `in_vc_ok` is high.
- `ST_SWREQ` goes back to `ST_IDLE` when a tail flit is granted. Otherwise it stays in `ST_SWREQ`.

Each output has a round-robin arbiter. Its pointer moves to one past the last winner.

Top module: `xsa_switch_alloc`

## Requirements
- R1: A head flit first presented in cycle t, with `in_vc_ok` high throughout, is popped in cycle t+3. Its output then shows `xb_valid`=1 in cycle t+4.
- R2: Body and tail flits of a packet already in `ST_SWREQ`, and without contention, are popped in the cycle they are presented. Their traversal appears in the next cycle.
- R3: While `in_vc_ok` is low in `ST_VCWAIT`, the head flit is not popped. It is popped one cycle after the cycle in which `in_vc_ok` goes high.
- R4: `in_pop[i]` is never high unless both `in_valid[i]` and `in_vc_ok[i]` are high. A body flit with `in_vc_ok` low waits.
- R5: `la_bit[o]` high in cycle t gives `xb_valid[o]`=1, `xb_express[o]`=1 and `xb_sel[o]`=N_IVC (the express-lane code) in cycle t+1. `xb_express[o]` is never high without the lookahead one cycle before.
- R6: An ordinary request for output o is not granted in a cycle in which `la_bit[o]` is high. The flit is retried and granted in the next free cycle. A lookahead on another output does not block it.
- R7: Among competing ordinary requests for one output, the lowest index wins after reset. After that, priority starts one past the previous winner.
- R8: Each output carries at most one flit per cycle. The number of ordinary traversals in cycle t+1 equals the number of pops in cycle t, and different outputs may be granted in the same cycle.
- R9: After a tail flit is granted, the channel returns to `ST_IDLE`. The next head flit goes through the full route and VC-wait stages again.
- R10: After reset, `xb_valid` and `in_pop` are all zero.
- R11: For an ordinary traversal, `xb_sel[o]` equals the index of the input virtual channel that won.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_IVC | A flit is present at the head of each input VC buffer |
| in_head | input | N_IVC | The present flit is a head flit |
| in_tail | input | N_IVC | The present flit is a tail flit |
| in_dest | input | N_IVC x OW | Output port chosen by routing for each input VC |
| in_vc_ok | input | N_IVC | Downstream VC and buffer confirmed for each input VC |
| la_bit | input | N_OUT | Express lookahead for each output, one cycle ahead of the flit |
| in_pop | output | N_IVC | Grant that dequeues the flit this cycle |
| xb_valid | output | N_OUT | Output carries a flit this cycle |
| xb_express | output | N_OUT | The carried flit comes from the express lane |
| xb_sel | output | N_OUT x SW | Crossbar source: input VC index, or N_IVC for the express lane |

## Verification
`in_pop` is combinational and is due in the cycle the allocation is made. Every crossbar output (`xb_valid`, `xb_express`, `xb_sel`) appears exactly one cycle after the grant or lookahead that caused it. A head flit adds three cycles before its pop, and a `ST_VCWAIT` stall adds one cycle after `in_vc_ok` rises. The bench drives inputs just after the falling edge, waits 1 ns, and then reads `in_pop` for the current cycle and the crossbar outputs for the previous cycle's decisions. Each scenario counts cycles from reset so that the arbiter pointer is known.

// File: rtl/xsa_pkg.sv
package xsa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ROUTE  = 2'd1,
        ST_VCWAIT = 2'd2,
        ST_SWREQ  = 2'd3
    } vc_state_e;
endpackage

// File: rtl/xsa_vc_fsm.sv
module xsa_vc_fsm
    import xsa_pkg::*;
#(
    parameter int OW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flit_valid,
    input  logic          flit_head,
    input  logic          flit_tail,
    input  logic [OW-1:0] route_dest,
    input  logic          vc_ok,
    input  logic          granted,
    output logic          sw_req,
    output logic [OW-1:0] req_dest
);
    vc_state_e state, state_n;
    logic [OW-1:0] dest_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            dest_q <= '0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && flit_valid && flit_head)
                dest_q <= route_dest;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (flit_valid && flit_head) state_n = ST_ROUTE;
            ST_ROUTE:  state_n = ST_VCWAIT;
            ST_VCWAIT: if (vc_ok) state_n = ST_SWREQ;
            ST_SWREQ:  if (granted && flit_tail) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sw_req   = (state == ST_SWREQ) && flit_valid && vc_ok;
        req_dest = dest_q;
    end
endmodule

// File: rtl/xsa_rr_arb.sv
module xsa_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         block,
    output logic [N-1:0] gnt,
    output logic         any
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] ptr, win;
    logic [N-1:0]  req_m;

    always_comb begin
        int idx;
        req_m = block ? '0 : req;
        gnt   = '0;
        any   = 1'b0;
        win   = '0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + k) % N;
            if (!any && req_m[idx]) begin
                gnt[idx] = 1'b1;
                any      = 1'b1;
                win      = PW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (any)
            ptr <= (win == PW'(N-1)) ? '0 : win + 1'b1;
    end
endmodule

// File: rtl/xsa_switch_alloc.sv
module xsa_switch_alloc #(
    parameter int N_IVC = 4,
    parameter int N_OUT = 3,
    parameter int OW    = (N_OUT > 1) ? $clog2(N_OUT) : 1,
    parameter int SW    = $clog2(N_IVC + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_IVC-1:0]            in_valid,
    input  logic [N_IVC-1:0]            in_head,
    input  logic [N_IVC-1:0]            in_tail,
    input  logic [N_IVC-1:0][OW-1:0]    in_dest,
    input  logic [N_IVC-1:0]            in_vc_ok,
    input  logic [N_OUT-1:0]            la_bit,
    output logic [N_IVC-1:0]            in_pop,
    output logic [N_OUT-1:0]            xb_valid,
    output logic [N_OUT-1:0]            xb_express,
    output logic [N_OUT-1:0][SW-1:0]    xb_sel
);
    localparam logic [SW-1:0] EXP_SEL = SW'(N_IVC);

    logic [N_IVC-1:0]               sw_req;
    logic [N_IVC-1:0][OW-1:0]       req_dest;
    logic [N_OUT-1:0][N_IVC-1:0]    req_mx;
    logic [N_OUT-1:0][N_IVC-1:0]    gnt_mx;
    logic [N_OUT-1:0]               gnt_any;
    logic [N_OUT-1:0][SW-1:0]       sel_n;

    for (genvar i = 0; i < N_IVC; i++) begin : g_vc
        xsa_vc_fsm #(.OW(OW)) fsm_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .flit_valid (in_valid[i]),
            .flit_head  (in_head[i]),
            .flit_tail  (in_tail[i]),
            .route_dest (in_dest[i]),
            .vc_ok      (in_vc_ok[i]),
            .granted    (in_pop[i]),
            .sw_req     (sw_req[i]),
            .req_dest   (req_dest[i])
        );
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++)
            for (int i = 0; i < N_IVC; i++)
                req_mx[o][i] = sw_req[i] && (req_dest[i] == OW'(o));
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        xsa_rr_arb #(.N(N_IVC)) arb_i (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_mx[o]),
            .block (la_bit[o]),
            .gnt   (gnt_mx[o]),
            .any   (gnt_any[o])
        );
    end

    always_comb begin
        in_pop = '0;
        for (int o = 0; o < N_OUT; o++) begin
            in_pop   = in_pop | gnt_mx[o];
            sel_n[o] = la_bit[o] ? EXP_SEL : '0;
            for (int i = 0; i < N_IVC; i++)
                if (!la_bit[o] && gnt_mx[o][i]) sel_n[o] = SW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xb_valid   <= '0;
            xb_express <= '0;
            xb_sel     <= '0;
        end else begin
            xb_valid   <= la_bit | gnt_any;
            xb_express <= la_bit;
            xb_sel     <= sel_n;
        end
    end
endmodule

// File: rtl/xsa_sva.sv
module xsa_sva #(
    parameter int N_IVC = 4,
    parameter int N_OUT = 3,
    parameter int OW    = (N_OUT > 1) ? $clog2(N_OUT) : 1,
    parameter int SW    = $clog2(N_IVC + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_IVC-1:0]            in_valid,
    input logic [N_IVC-1:0]            in_head,
    input logic [N_IVC-1:0]            in_tail,
    input logic [N_IVC-1:0][OW-1:0]    in_dest,
    input logic [N_IVC-1:0]            in_vc_ok,
    input logic [N_OUT-1:0]            la_bit,
    input logic [N_IVC-1:0]            in_pop,
    input logic [N_OUT-1:0]            xb_valid,
    input logic [N_OUT-1:0]            xb_express,
    input logic [N_OUT-1:0][SW-1:0]    xb_sel
);
    localparam logic [SW-1:0] EXP_SEL = SW'(N_IVC);

    AST_POP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pop & ~(in_valid & in_vc_ok)) == '0); // R4

    AST_POP_MATCHES_TRAVERSAL: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(xb_valid & ~xb_express) == $past($countones(in_pop)))); // R8

    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pop == '0 && la_bit == '0) |=> (xb_valid == '0)); // R8

    for (genvar o = 0; o < N_OUT; o++) begin : g_o
        AST_EXPRESS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
            la_bit[o] |=> (xb_valid[o] && xb_express[o] && xb_sel[o] == EXP_SEL)); // R5

        AST_EXPRESS_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
            xb_express[o] |-> $past(la_bit[o])); // R5

        AST_NORMAL_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (xb_valid[o] && !xb_express[o]) |-> (xb_sel[o] < EXP_SEL)); // R11
    end
endmodule

bind xsa_switch_alloc xsa_sva #(.N_IVC(N_IVC), .N_OUT(N_OUT), .OW(OW), .SW(SW)) chk_i (.*);

// File: tb/xsa_switch_alloc_tb_top.sv
module xsa_switch_alloc_tb_top;
    localparam int N_IVC = 4;
    localparam int N_OUT = 3;
    localparam int OW    = 2;
    localparam int SW    = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic [N_IVC-1:0]         in_valid, in_head, in_tail, in_vc_ok;
    logic [N_IVC-1:0][OW-1:0] in_dest;
    logic [N_OUT-1:0]         la_bit;
    logic [N_IVC-1:0]         in_pop;
    logic [N_OUT-1:0]         xb_valid, xb_express;
    logic [N_OUT-1:0][SW-1:0] xb_sel;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    xsa_switch_alloc #(.N_IVC(N_IVC), .N_OUT(N_OUT)) dut_i (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_pop(input logic [N_IVC-1:0] exp, input string req);
        check(in_pop == exp, req, "in_pop", int'(in_pop), int'(exp));
    endtask

    // ordinary traversal on output o from input src
    task automatic chk_norm(input int o, input int src, input string req);
        check(xb_valid[o] && !xb_express[o] && xb_sel[o] == SW'(src), req,
              $sformatf("out%0d valid/exp/sel", o),
              {xb_valid[o], xb_express[o], xb_sel[o]}, {2'b10, SW'(src)});
    endtask

    task automatic chk_exp(input int o, input string req);
        check(xb_valid[o] && xb_express[o] && xb_sel[o] == SW'(N_IVC), req,
              $sformatf("out%0d express", o),
              {xb_valid[o], xb_express[o], xb_sel[o]}, {2'b11, SW'(N_IVC)});
    endtask

    task automatic chk_quiet(input string req);
        check(xb_valid == '0, req, "xb_valid", int'(xb_valid), 0);
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = '0; in_head = '0; in_tail = '0; in_vc_ok = '0;
        in_dest = '0; la_bit = '0;
        repeat (2) nxt();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        settle();
        chk_pop('0, "R10");
        chk_quiet("R10");
    endtask

    // one packet of head, body, tail, then a single-flit packet
    task automatic t_packet();
        do_reset();
        nxt(); in_valid[1] = 1; in_head[1] = 1; in_dest[1] = 2; in_vc_ok[1] = 1;
        settle(); chk_pop('0, "R1");
        nxt(); settle(); chk_pop('0, "R1");
        nxt(); settle(); chk_pop('0, "R1");
        nxt(); settle(); chk_pop(4'b0010, "R1");
        nxt(); in_head[1] = 0; settle(); chk_pop(4'b0010, "R2"); chk_norm(2, 1, "R1 R11");
        nxt(); in_tail[1] = 1; settle(); chk_pop(4'b0010, "R2"); chk_norm(2, 1, "R2");
        nxt(); in_head[1] = 1; settle(); chk_pop('0, "R9"); chk_norm(2, 1, "R2");
        nxt(); settle(); chk_pop('0, "R9"); chk_quiet("R8");
        nxt(); settle(); chk_pop('0, "R9");
        nxt(); settle(); chk_pop(4'b0010, "R9");
        nxt(); in_valid[1] = 0; settle(); chk_pop('0, "R9"); chk_norm(2, 1, "R9");
        nxt(); settle(); chk_quiet("R8");
    endtask

    task automatic t_vcwait();
        do_reset();
        nxt(); in_valid[0] = 1; in_head[0] = 1; in_dest[0] = 0; in_vc_ok[0] = 0;
        settle(); chk_pop('0, "R3");
        for (int c = 0; c < 6; c++) begin
            nxt(); settle(); chk_pop('0, "R3");
        end
        nxt(); in_vc_ok[0] = 1; settle(); chk_pop('0, "R3");
        nxt(); settle(); chk_pop(4'b0001, "R3");
        nxt(); in_head[0] = 0; in_vc_ok[0] = 0; settle();
        chk_pop('0, "R4"); chk_norm(0, 0, "R3");
        nxt(); settle(); chk_pop('0, "R4"); chk_quiet("R4");
        nxt(); in_vc_ok[0] = 1; in_tail[0] = 1; settle(); chk_pop(4'b0001, "R4");
        nxt(); in_valid[0] = 0; settle(); chk_norm(0, 0, "R4");
    endtask

    task automatic t_express();
        do_reset();
        nxt(); la_bit[1] = 1; settle(); chk_quiet("R5");
        nxt(); la_bit[1] = 0; settle(); chk_exp(1, "R5");
        nxt(); la_bit[2] = 1; settle(); chk_quiet("R5");
        nxt(); settle(); chk_exp(2, "R5");
        nxt(); la_bit[2] = 0; settle(); chk_exp(2, "R5");
        nxt(); settle(); chk_quiet("R5");
    endtask

    task automatic t_yield();
        do_reset();
        nxt(); in_valid[2] = 1; in_head[2] = 1; in_dest[2] = 1; in_vc_ok[2] = 1;
        settle();
        nxt(); settle(); nxt(); settle();
        nxt(); settle(); chk_pop(4'b0100, "R1");
        nxt(); in_head[2] = 0; la_bit[1] = 1; settle();
        chk_pop('0, "R6"); chk_norm(1, 2, "R11");
        nxt(); la_bit[1] = 0; la_bit[0] = 1; settle();
        chk_pop(4'b0100, "R6"); chk_exp(1, "R5");
        nxt(); la_bit[0] = 0; in_valid[2] = 0; settle();
        chk_norm(1, 2, "R6"); chk_exp(0, "R6");
    endtask

    task automatic t_rr();
        do_reset();
        nxt();
        for (int i = 0; i < N_IVC; i++) begin
            in_valid[i] = 1; in_head[i] = 1; in_vc_ok[i] = 1;
            in_dest[i] = (i == 3) ? 2'd2 : 2'd0;
        end
        settle(); chk_pop('0, "R1");
        nxt(); settle(); nxt(); settle();
        nxt(); settle(); chk_pop(4'b1001, "R7");
        nxt(); in_head = '0; settle(); chk_pop(4'b1010, "R7");
        chk_norm(0, 0, "R8"); chk_norm(2, 3, "R8");
        nxt(); settle(); chk_pop(4'b1100, "R7"); chk_norm(0, 1, "R7");
        nxt(); settle(); chk_pop(4'b1001, "R7"); chk_norm(0, 2, "R7");
        nxt(); in_valid = '0; settle(); chk_norm(0, 0, "R7"); chk_norm(2, 3, "R8");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_packet();
        t_vcwait();
        t_express();
        t_yield();
        t_rr();
        finish_run();
    end

    initial begin
        #(200000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        finish_run();
    end
endmodule